// File: doc/BRIEF.md
# Paged Write Buffer Controller

This block sits behind an SRAM-style host bus (active-low chip select, output enable and write strobe, plus address and data) and collects byte writes into a one-page staging buffer of 2^PAGE_BITS bytes. Every accepted byte sets a per-slot "loaded" flag. Bytes may arrive in any order, and a slot may be written more than once. While bytes keep arriving within a byte-load window, the page stays open. When the window runs out with no new byte, the block enters a programming phase of fixed length. At the end of that phase it copies the flagged slots into its internal byte array in one step and leaves every other location untouched.

The host bus is sampled on the system clock. All timing limits are cycle counts set by parameters. A write pulse has to stay active for a minimum number of samples before it counts, which filters out noise on the strobes. During programming the block raises `busy` and ignores all writes. A write to a page other than the open one is dropped and sets a sticky violation flag. The address and data of the last accepted byte are available on status outputs. A host read returns array contents one cycle after the read is sampled.

Top module: `pgbuf_top`

## Requirements
- R1: A sample is write-active only when `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe made while `oe_n`=0 or while `ce_n`=1 loads nothing and starts no programming.
- R2: The byte address is taken from the first write-active sample of a pulse. The data byte is taken from the last write-active sample of the pulse.
- R3: A write pulse with fewer than GLITCH_MIN consecutive write-active samples is discarded.
- R4: Slots load in any order, and a rewrite of a slot replaces its earlier value. Only slots loaded in the page are changed in the array. All other bytes of that page keep their old contents.
- R5: A byte is accepted two clock edges after the last write-active sample of its pulse, and the page address is latched when the first byte of a page is accepted. `busy` rises on the WIN_CYC-th edge after the last accepted byte. A matching byte accepted on that same edge wins: it restarts the window, and programming does not start.
- R6: `busy` stays high for PROG_CYC cycles. Strobes that complete while `busy` is high are discarded.
- R7: On the edge where `busy` falls, all flagged slots are written to the array at address {page, slot}, and all flags clear. A later page never rewrites slots from an earlier page.
- R8: While a page is open, a byte whose upper address bits (above PAGE_BITS) differ from the latched page is discarded. It does not restart the window, and it sets `page_viol`, which stays set until reset.
- R9: `last_addr` and `last_data` take the address and data of each accepted byte on its acceptance edge, and hold otherwise.
- R10: When a sample has `ce_n`=0, `oe_n`=0 and `we_n`=1, `rdata` shows the array byte at `addr` after the next edge. Otherwise `rdata` holds its value.
- R11: Synchronous active-low reset clears `busy`, `page_viol`, `last_addr`, `last_data`, `rdata`, all flags and the whole array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address; upper bits are the page, low PAGE_BITS are the slot |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | Programming phase in progress |
| page_viol | output | 1 | Sticky flag: a write to a foreign page was dropped |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | DATA_W | Data of the last accepted byte |

## Verification
Two functions can land on the same clock edge: the expiry of the byte-load window and the acceptance of a new byte. The resolution rule is in R5. To provoke the collision, the bench sends two-byte pages and sweeps the gap between the two pulses across the window boundary, so that one gap puts the second byte exactly on the expiry edge. The bench's behavioural model applies the R5 rule, and every cycle it compares `busy`, the status outputs and the read data from the array. A wrong priority shows up as an early `busy` or as a missing byte when the page is read back.

// File: rtl/pgbuf_pkg.sv
// Shared types for the paged write buffer controller.
package pgbuf_pkg;
    // Page-control phases: no page open, page collecting bytes, programming.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pg_state_t;
endpackage

// File: rtl/pgbuf_strobe.sv
// Host write strobe front end.
// Turns sampled SRAM-style control lines into single-cycle byte events.
// The address comes from the first write-active sample and the data from the
// last one. Pulses shorter than GLITCH_MIN samples are dropped.
// Assumes the bus inputs are already synchronous to clk.
module pgbuf_strobe #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int GLITCH_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              acc_vld,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data
);
    localparam int LEN_W = $clog2(GLITCH_MIN + 1);

    logic             act;
    logic             act_q;
    logic [LEN_W-1:0] len;

    // Write-active: chip selected, strobe low, output drivers off.
    assign act = !ce_n && !we_n && oe_n;

    // Track pulse length and capture fields; emit an event when a pulse ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            len      <= '0;
            acc_vld  <= 1'b0;
            acc_addr <= '0;
            acc_data <= '0;
        end else begin
            act_q   <= act;
            acc_vld <= 1'b0;
            if (act) begin
                if (!act_q) begin
                    acc_addr <= addr;
                    len      <= LEN_W'(1);
                end else if (len != LEN_W'(GLITCH_MIN)) begin
                    len <= len + LEN_W'(1);
                end
                acc_data <= din;
            end else if (act_q) begin
                acc_vld <= (len >= LEN_W'(GLITCH_MIN));
            end
        end
    end
endmodule

// File: rtl/pgbuf_ctrl.sv
// Page controller: staging buffer, loaded-slot flags, byte-load window and
// programming timer. Raises commit for one cycle at the end of programming,
// while the flags still hold; it clears them on that same edge.
// Assumes acc_vld is a single-cycle event from the strobe front end.
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8,
    parameter int WIN_CYC   = 18750,
    parameter int PROG_CYC  = 1250000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 acc_vld,
    input  logic [ADDR_W-1:0]                    acc_addr,
    input  logic [DATA_W-1:0]                    acc_data,
    output logic                                 busy,
    output logic                                 loading,
    output logic                                 commit,
    output logic [ADDR_W-PAGE_BITS-1:0]          page_q,
    output logic [(1<<PAGE_BITS)-1:0]            slot_vld,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] slot_dat,
    output logic                                 page_viol,
    output logic [ADDR_W-1:0]                    last_addr,
    output logic [DATA_W-1:0]                    last_data
);
    localparam int PG_W  = ADDR_W - PAGE_BITS;
    localparam int MAXC  = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    pg_state_t           state;
    logic [CNT_W-1:0]    cnt;
    logic [PG_W-1:0]     in_page;
    logic [PAGE_BITS-1:0] in_slot;
    logic                same_page;
    logic                win_end;

    // Split the incoming address and decode the timer end points.
    assign in_page   = acc_addr[ADDR_W-1:PAGE_BITS];
    assign in_slot   = acc_addr[PAGE_BITS-1:0];
    assign same_page = (in_page == page_q);
    assign win_end   = (cnt == CNT_W'(WIN_CYC - 1));
    assign commit    = (state == ST_PROG) && (cnt == CNT_W'(PROG_CYC - 1));
    assign busy      = (state == ST_PROG);
    assign loading   = (state == ST_LOAD);

    // Phase sequencing, slot loading, window and programming counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            page_q    <= '0;
            slot_vld  <= '0;
            slot_dat  <= '0;
            page_viol <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (acc_vld) begin
                        page_q            <= in_page;
                        slot_vld[in_slot] <= 1'b1;
                        slot_dat[in_slot] <= acc_data;
                        last_addr         <= acc_addr;
                        last_data         <= acc_data;
                        cnt               <= '0;
                        state             <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (acc_vld && same_page) begin
                        slot_vld[in_slot] <= 1'b1;
                        slot_dat[in_slot] <= acc_data;
                        last_addr         <= acc_addr;
                        last_data         <= acc_data;
                        cnt               <= '0;
                    end else begin
                        if (acc_vld) page_viol <= 1'b1;
                        if (win_end) begin
                            cnt   <= '0;
                            state <= ST_PROG;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        cnt      <= '0;
                        slot_vld <= '0;
                        state    <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgbuf_array.sv
// Byte array behind the buffer. On commit it writes every flagged slot of the
// staged page in one cycle. It has one registered read port.
// Assumes commit is a single-cycle pulse and page/flags/data are stable with it.
module pgbuf_array #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  commit,
    input  logic [ADDR_W-PAGE_BITS-1:0]           page,
    input  logic [(1<<PAGE_BITS)-1:0]             slot_vld,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] slot_dat,
    input  logic                                  rd_en,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                     rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PAGE_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset; otherwise commit the flagged slots of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_vld[s]) mem[{page, s[PAGE_BITS-1:0]}] <= slot_dat[s];
            end
        end
    end

    // Registered host read; the value holds when no read is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pgbuf_top.sv
// Paged write buffer controller top: strobe front end, page controller and
// byte array. The host bus is assumed to be synchronous to clk.
module pgbuf_top #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BITS  = 8,
    parameter int GLITCH_MIN = 2,
    parameter int WIN_CYC    = 18750,
    parameter int PROG_CYC   = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              page_viol,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int PG_W  = ADDR_W - PAGE_BITS;
    localparam int SLOTS = 1 << PAGE_BITS;

    logic                         acc_vld;
    logic [ADDR_W-1:0]            acc_addr;
    logic [DATA_W-1:0]            acc_data;
    logic                         loading;
    logic                         commit;
    logic [PG_W-1:0]              page_q;
    logic [SLOTS-1:0]             slot_vld;
    logic [SLOTS-1:0][DATA_W-1:0] slot_dat;
    logic                         rd_en;

    // Host read qualifier.
    assign rd_en = !ce_n && !oe_n && we_n;

    pgbuf_strobe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH_MIN)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(wdata),
        .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_data(acc_data)
    );

    pgbuf_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
        .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_data(acc_data),
        .busy(busy), .loading(loading), .commit(commit), .page_q(page_q),
        .slot_vld(slot_vld), .slot_dat(slot_dat), .page_viol(page_viol),
        .last_addr(last_addr), .last_data(last_data)
    );

    pgbuf_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(page_q),
        .slot_vld(slot_vld), .slot_dat(slot_dat),
        .rd_en(rd_en), .rd_addr(addr), .rd_data(rdata)
    );
endmodule

// File: rtl/pgbuf_chk.sv
// Temporal checks for pgbuf_top. Bound into every instance of the top.
module pgbuf_chk #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ce_n,
    input logic                        oe_n,
    input logic                        we_n,
    input logic [DATA_W-1:0]           rdata,
    input logic                        busy,
    input logic                        page_viol,
    input logic [ADDR_W-1:0]           last_addr,
    input logic [DATA_W-1:0]           last_data,
    input logic                        acc_vld,
    input logic                        loading,
    input logic [(1<<PAGE_BITS)-1:0]   slot_vld
);
    // The violation flag never clears on its own.
    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        page_viol |=> page_viol);

    // Nothing is accepted while programming.
    p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    // Status changes only when the front end delivers a byte.
    p_last_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> ($stable(last_addr) && $stable(last_data)));

    // Programming only follows an open page.
    p_prog_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(loading));

    // Flags are empty once programming ends.
    p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($countones(slot_vld) == 0));

    // Read data holds when no read is sampled.
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> $stable(rdata));
endmodule

bind pgbuf_top pgbuf_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rdata(rdata), .busy(busy), .page_viol(page_viol),
    .last_addr(last_addr), .last_data(last_data),
    .acc_vld(acc_vld), .loading(loading), .slot_vld(slot_vld)
);

// File: tb/pgbuf_top_bench.sv
// Bench for pgbuf_top: a behavioural reference model is compared every cycle,
// plus directed read-back checks.
module pgbuf_top_bench;
    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int PB  = 8;
    localparam int GL  = 3;
    localparam int WIN = 20;
    localparam int PRG = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          busy, page_viol;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    pgbuf_top #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .GLITCH_MIN(GL),
        .WIN_CYC(WIN), .PROG_CYC(PRG)
    ) u_pgbuf_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
        .page_viol(page_viol), .last_addr(last_addr), .last_data(last_data)
    );

    // ---------------- reference model ----------------
    int       m_state;            // 0 no page, 1 collecting, 2 programming
    int       m_cnt;
    int       m_page;
    bit       m_flag [1<<PB];
    int       m_buf  [1<<PB];
    int       m_mem  [1<<AW];
    int       m_viol, m_la, m_ld, m_rd;
    bit       m_prev;
    int       m_len, m_a, m_d;
    bit       m_pend;
    bit       m_started = 1'b0;

    always @(posedge clk) begin
        m_started <= 1'b1;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_page = 0;
            foreach (m_flag[i]) begin m_flag[i] = 0; m_buf[i] = 0; end
            foreach (m_mem[i]) m_mem[i] = 0;
            m_viol = 0; m_la = 0; m_ld = 0; m_rd = 0;
            m_prev = 0; m_len = 0; m_a = 0; m_d = 0; m_pend = 0;
        end else begin
            bit act;
            bit np;
            // host read uses the array as it was before this edge (R10)
            if (!ce_n && !oe_n && we_n) m_rd = m_mem[addr];
            // page handling on the byte delivered from the previous edge
            if (m_state == 2) begin
                if (m_cnt == PRG - 1) begin
                    foreach (m_flag[s]) if (m_flag[s]) begin
                        m_mem[m_page * (1 << PB) + s] = m_buf[s];
                        m_flag[s] = 0;
                    end
                    m_state = 0; m_cnt = 0;
                end else m_cnt++;
            end else if (m_pend && (m_state == 0 || (m_a >> PB) == m_page)) begin
                if (m_state == 0) m_page = m_a >> PB;
                m_flag[m_a % (1 << PB)] = 1;
                m_buf[m_a % (1 << PB)]  = m_d;
                m_la = m_a; m_ld = m_d; m_cnt = 0; m_state = 1;
            end else if (m_state == 1) begin
                if (m_pend) m_viol = 1;
                if (m_cnt == WIN - 1) begin m_state = 2; m_cnt = 0; end
                else m_cnt++;
            end
            // bus front end
            act = !ce_n && !we_n && oe_n;
            np  = 0;
            if (act) begin
                if (!m_prev) begin m_a = addr; m_len = 1; end
                else m_len++;
                m_d = wdata;
            end else if (m_prev) np = (m_len >= GL);
            m_prev = act;
            m_pend = np;
        end
    end

    task automatic cmp(input string what, input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (m_started) begin
            cmp("busy",      "R5 R6", int'(busy),      (m_state == 2) ? 1 : 0);
            cmp("page_viol", "R8",    int'(page_viol), m_viol);
            cmp("last_addr", "R9",    int'(last_addr), m_la);
            cmp("last_data", "R9",    int'(last_data), m_ld);
            cmp("rdata",     "R10",   int'(rdata),     m_rd);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int len, input logic ce_v, input logic oe_v);
        @(negedge clk);
        ce_n = ce_v; oe_n = oe_v; we_n = 1'b0; addr = a;
        wdata = (len == 1) ? d : ~d;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            addr = ~a;                       // R2: later address must not matter
            if (i == len - 1) wdata = d;     // R2: last sample carries the data
        end
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
        pulse(a, d, len, 1'b0, 1'b1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_state != 0 || m_pend || m_prev) @(negedge clk);
        idle(2);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input int exp, input string req);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        cmp($sformatf("read %0h", a), req, int'(rdata), exp);
    endtask

    initial begin
        idle(4);
        // R11: reset state
        cmp("reset busy", "R11", int'(busy), 0);
        cmp("reset viol", "R11", int'(page_viol), 0);
        cmp("reset rdata", "R11", int'(rdata), 0);
        rst_n = 1'b1;
        idle(2);
        rd_chk(10'h0FF, 0, "R11");

        // R4 R2: out-of-order loads with a rewrite on page 1
        wr(10'h105, 8'h11, 3);
        wr(10'h103, 8'h22, 4);
        wr(10'h105, 8'h33, 3);
        wr(10'h1C8, 8'h44, 3);
        idle(WIN + 4);
        cmp("busy after window", "R5", int'(busy), 1);
        wr(10'h1AA, 8'h55, 3);               // R6: during programming
        wait_idle();
        rd_chk(10'h105, 8'h33, "R4");
        rd_chk(10'h103, 8'h22, "R2");
        rd_chk(10'h1C8, 8'h44, "R7");
        rd_chk(10'h104, 0,     "R4");
        rd_chk(10'h1AA, 0,     "R6");
        cmp("last_addr", "R9", int'(last_addr), 10'h1C8);
        cmp("last_data", "R9", int'(last_data), 8'h44);

        // R3: short pulse is filtered
        wr(10'h200, 8'h66, GL - 1);
        idle(WIN + 5);
        cmp("busy after glitch", "R3", int'(busy), 0);
        rd_chk(10'h200, 0, "R3");

        // R1: write inhibited by oe low and by ce high
        pulse(10'h201, 8'h77, 4, 1'b0, 1'b0);
        pulse(10'h202, 8'h78, 4, 1'b1, 1'b1);
        idle(WIN + 5);
        cmp("busy after inhibited", "R1", int'(busy), 0);
        rd_chk(10'h201, 0, "R1");
        rd_chk(10'h202, 0, "R1");

        // R8: foreign page dropped, sticky flag
        wr(10'h207, 8'hAA, 3);
        wr(10'h308, 8'hBB, 3);
        idle(3);
        cmp("viol set", "R8", int'(page_viol), 1);
        wait_idle();
        rd_chk(10'h207, 8'hAA, "R8");
        rd_chk(10'h308, 0,     "R8");

        // R7: flags cleared, new page does not inherit slot 7
        wr(10'h309, 8'hCC, 3);
        wait_idle();
        rd_chk(10'h307, 0,     "R7");
        rd_chk(10'h309, 8'hCC, "R7");
        cmp("viol still set", "R8", int'(page_viol), 1);

        // R5: sweep second-byte gap across the window boundary
        for (int g = WIN - 8; g <= WIN + 1; g++) begin
            wr(AW'(g), 8'(g), 3);
            idle(g);
            wr(AW'(g + 100), 8'(g + 50), 3);
            wait_idle();
            rd_chk(AW'(g + 100), m_mem[g + 100], "R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule